// File: doc/BRIEF.md
# Programmable Parallel I/O Port Controller

This block gives a processor three 8-bit general-purpose ports behind one 8-bit register interface. Port A and port B each have a single direction. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. A two-bit select chooses which port is accessed, or the control word instead. Chip select, read and write are all active-low. Each port brings out three separate vectors: one for input, one for output and one for output enable. A pad ring or board model outside the block resolves them to pins.

A control word with its top bit set is a mode-set word. It gives the direction of the four port sections and stores the mode fields for the two groups. Group A is port A plus the upper nibble of C. Group B is port B plus the lower nibble of C. Only basic input/output is carried out. The handshake modes can be stored and read back, but they change nothing on the ports. A control word with its top bit clear is a port C single-bit set/reset command. It leaves the stored control word unchanged.

All writes take effect on the rising clock edge during which chip select and write are both low. Read data is combinational while the read strobe is held.

Top module: `ppio_ctrl`

## Requirements
- R1: The select input decodes as 00 port A, 01 port B, 10 port C and 11 control word, for both reads and writes.
- R2: `bus_oe` is high only while `cs_n`=0, `rd_n`=0 and `wr_n`=1. Otherwise it is low.
- R3: When `rst` is high, the control word becomes 9Bh, every output latch is cleared to 0 and every output enable is low.
- R4: A mode-set word has bit 7=1. Bit 4 is the port A direction, bit 3 the upper C direction, bit 1 the port B direction and bit 0 the lower C direction, where 1 means input. Each port section drives an all-ones output enable when it is set to output.
- R5: A read of select 11 returns bit 7 as 1 and bits 6:0 exactly as last written. The mode fields (bits 6:5 for group A, bit 2 for group B) are stored but do not change any port behaviour.
- R6: A mode-set write clears the output latch of every section that it makes an output. The latch of a section that stays or becomes an input keeps its value.
- R7: A write to select 11 with bit 7=0 sets port C bit [3:1] to the value in bit 0. All other port C bits and the control word stay unchanged.
- R8: A read of port A as input returns the value captured at the last clock edge before the read began. Pin changes while the read is held do not affect it.
- R9: A read of port B as input returns the live pin value. Each port C nibble set as input returns its live pins, and a nibble set as output returns its latch.
- R10: A data write to an output section updates its output one cycle later, and a read of that section returns the latch.
- R11: A data write to an input section changes only its latch. The output enable stays low, and a later mode-set that makes it an output still clears the latch to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| sel | input | 2 | Port/control select |
| bus_wdata | input | 8 | Write data from the processor |
| bus_rdata | output | 8 | Read data to the processor |
| bus_oe | output | 1 | Read data valid / bus drive enable |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enable |

## Verification
The interaction that matters is between the port A input capture and an active read of port A. Both can involve the same clock edge. The bench changes `pa_in` on the falling edge inside a held read, so the next rising edge sees both the new pin value and the read strobe. It then judges the read data both before and after that edge against the value captured before the read began. A second coincidence is tested as well: a mode-set that makes a section an output while that section's latch holds data written while it was an input. Here the clear must take priority over the stale data.

// File: rtl/ppio_pkg.sv
package ppio_pkg;

    localparam int DW = 8;
    localparam int NIB = DW / 2;
    localparam logic [DW-1:0] CTL_RESET = 8'h9B;

    typedef enum logic [1:0] {
        SEL_A   = 2'b00,
        SEL_B   = 2'b01,
        SEL_C   = 2'b10,
        SEL_CTL = 2'b11
    } sel_e;

    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_is_in;
        logic       cu_is_in;
        logic       grp_b_mode;
        logic       b_is_in;
        logic       cl_is_in;
    } ctl_t;

    function automatic ctl_t to_ctl(input logic [DW-1:0] w);
        return ctl_t'(w[DW-2:0]);
    endfunction

    function automatic logic [DW-1:0] ctl_readback(input ctl_t c);
        return {1'b1, c};
    endfunction

endpackage

// File: rtl/ppio_bus_dec.sv
module ppio_bus_dec
    import ppio_pkg::*;
(
    input  logic       cs_n,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [1:0] sel,
    output logic       rd_act,
    output logic       rd_a,
    output logic [3:0] wr_stb
);
    logic wr_act;

    assign wr_act = !cs_n && !wr_n;
    assign rd_act = !cs_n && !rd_n && wr_n;
    assign rd_a   = rd_act && (sel_e'(sel) == SEL_A);

    for (genvar i = 0; i < 4; i++) begin : g_stb
        assign wr_stb[i] = wr_act && (sel == 2'(i));
    end
endmodule

// File: rtl/ppio_ctl_reg.sv
module ppio_ctl_reg
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_ctl,
    input  logic [DW-1:0] wdata,
    output ctl_t          ctl_q,
    output ctl_t          ctl_next,
    output logic          mset,
    output logic          bsr,
    output logic [2:0]    bsr_idx,
    output logic          bsr_val
);
    assign mset     = wr_ctl && wdata[DW-1];
    assign bsr      = wr_ctl && !wdata[DW-1];
    assign bsr_idx  = wdata[3:1];
    assign bsr_val  = wdata[0];
    assign ctl_next = to_ctl(wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= to_ctl(CTL_RESET);
        end else if (mset) begin
            ctl_q <= ctl_next;
        end
    end
endmodule

// File: rtl/ppio_port_slice.sv
module ppio_port_slice #(
    parameter int W        = 8,
    parameter bit LATCH_IN = 1'b0,
    localparam int IW      = (W > 1) ? $clog2(W) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          mset,
    input  logic          new_is_in,
    input  logic          is_in,
    input  logic          bit_we,
    input  logic [IW-1:0] bit_idx,
    input  logic          bit_val,
    input  logic          hold_in,
    input  logic [W-1:0]  pin_in,
    output logic [W-1:0]  pin_out,
    output logic [W-1:0]  pin_oe,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] out_q;
    logic [W-1:0] in_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else if (mset) begin
            if (!new_is_in) out_q <= '0;
        end else if (wr_en) begin
            out_q <= wr_data;
        end else if (bit_we) begin
            out_q[bit_idx] <= bit_val;
        end
    end

    if (LATCH_IN) begin : g_latched
        logic [W-1:0] lat_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                lat_q <= '0;
            end else if (!hold_in) begin
                lat_q <= pin_in;
            end
        end
        assign in_val = lat_q;
    end else begin : g_direct
        logic unused_hold;
        assign unused_hold = hold_in;
        assign in_val = pin_in;
    end

    assign pin_out = out_q;
    assign pin_oe  = {W{~is_in}};
    assign rd_data = is_in ? in_val : out_q;
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
    import ppio_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          bus_oe,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    logic       rd_act, rd_a;
    logic [3:0] wr_stb;
    ctl_t       ctl_q, ctl_next;
    logic       mset, bsr, bsr_val;
    logic [2:0] bsr_idx;
    logic [DW-1:0]  a_rd, b_rd;
    logic [NIB-1:0] cu_rd, cl_rd;

    ppio_bus_dec u_dec (
        .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
        .rd_act(rd_act), .rd_a(rd_a), .wr_stb(wr_stb)
    );

    ppio_ctl_reg u_ctl (
        .clk(clk), .rst(rst), .wr_ctl(wr_stb[SEL_CTL]), .wdata(bus_wdata),
        .ctl_q(ctl_q), .ctl_next(ctl_next), .mset(mset), .bsr(bsr),
        .bsr_idx(bsr_idx), .bsr_val(bsr_val)
    );

    ppio_port_slice #(.W(DW), .LATCH_IN(1'b1)) u_pa (
        .clk(clk), .rst(rst), .wr_en(wr_stb[SEL_A]), .wr_data(bus_wdata),
        .mset(mset), .new_is_in(ctl_next.a_is_in), .is_in(ctl_q.a_is_in),
        .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .hold_in(rd_a),
        .pin_in(pa_in), .pin_out(pa_out), .pin_oe(pa_oe), .rd_data(a_rd)
    );

    ppio_port_slice #(.W(DW), .LATCH_IN(1'b0)) u_pb (
        .clk(clk), .rst(rst), .wr_en(wr_stb[SEL_B]), .wr_data(bus_wdata),
        .mset(mset), .new_is_in(ctl_next.b_is_in), .is_in(ctl_q.b_is_in),
        .bit_we(1'b0), .bit_idx('0), .bit_val(1'b0), .hold_in(1'b0),
        .pin_in(pb_in), .pin_out(pb_out), .pin_oe(pb_oe), .rd_data(b_rd)
    );

    ppio_port_slice #(.W(NIB), .LATCH_IN(1'b0)) u_pcu (
        .clk(clk), .rst(rst), .wr_en(wr_stb[SEL_C]), .wr_data(bus_wdata[DW-1:NIB]),
        .mset(mset), .new_is_in(ctl_next.cu_is_in), .is_in(ctl_q.cu_is_in),
        .bit_we(bsr && bsr_idx[2]), .bit_idx(bsr_idx[1:0]), .bit_val(bsr_val),
        .hold_in(1'b0), .pin_in(pc_in[DW-1:NIB]), .pin_out(pc_out[DW-1:NIB]),
        .pin_oe(pc_oe[DW-1:NIB]), .rd_data(cu_rd)
    );

    ppio_port_slice #(.W(NIB), .LATCH_IN(1'b0)) u_pcl (
        .clk(clk), .rst(rst), .wr_en(wr_stb[SEL_C]), .wr_data(bus_wdata[NIB-1:0]),
        .mset(mset), .new_is_in(ctl_next.cl_is_in), .is_in(ctl_q.cl_is_in),
        .bit_we(bsr && !bsr_idx[2]), .bit_idx(bsr_idx[1:0]), .bit_val(bsr_val),
        .hold_in(1'b0), .pin_in(pc_in[NIB-1:0]), .pin_out(pc_out[NIB-1:0]),
        .pin_oe(pc_oe[NIB-1:0]), .rd_data(cl_rd)
    );

    always_comb begin
        case (sel_e'(sel))
            SEL_A:   bus_rdata = a_rd;
            SEL_B:   bus_rdata = b_rd;
            SEL_C:   bus_rdata = {cu_rd, cl_rd};
            default: bus_rdata = ctl_readback(ctl_q);
        endcase
    end

    assign bus_oe = rd_act;
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] sel,
    input logic [7:0] bus_wdata,
    input logic [7:0] bus_rdata,
    input logic       bus_oe,
    input logic [7:0] pa_in,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_oe
);
    logic ctl_wr;
    logic rd_a_in;
    assign ctl_wr  = !cs_n && !wr_n && (sel == 2'b11);
    assign rd_a_in = !cs_n && !rd_n && wr_n && (sel == 2'b00) && (pa_oe == 8'h00);

    assert_oe_gated_R2: assert property (@(posedge clk) disable iff (rst)
        bus_oe |-> (!cs_n && !rd_n && wr_n));

    assert_ctl_msb_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_oe && sel == 2'b11) |-> bus_rdata[7]);

    assert_clear_a_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && bus_wdata[7] && !bus_wdata[4]) |=> (pa_out == 8'h00 && pa_oe == 8'hFF));

    assert_bsr_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !bus_wdata[7]) |=> pc_out[$past(bus_wdata[3:1])] == $past(bus_wdata[0]));

    assert_bsr_keeps_dir_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !bus_wdata[7]) |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

    assert_a_read_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_a_in && $past(rd_a_in) && $past(!rst)) |-> $stable(bus_rdata));

    logic unused_pins;
    assign unused_pins = ^pa_in;
endmodule

bind ppio_ctrl ppio_ctrl_chk i_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe), .pc_out(pc_out),
    .pb_oe(pb_oe), .pc_oe(pc_oe)
);

// File: tb/test_ppio_ctrl.sv
module test_ppio_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] sel = 2'b00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic bus_oe;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppio_ctrl i_ppio_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .sel(sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        sel = s; bus_wdata = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
        #1;
    endtask

    task automatic bus_rd(input logic [1:0] s, output logic [7:0] d);
        @(negedge clk);
        sel = s; cs_n = 1'b0; rd_n = 1'b0;
        #1;
        d = bus_rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bus_rd(2'b11, v);
        chk("R3 control after reset", v, 8'h9B);
        chk("R3 pa_oe after reset", pa_oe, 8'h00);
        chk("R3 pc_oe after reset", pc_oe, 8'h00);
        chk("R3 pb_out after reset", pb_out, 8'h00);
    endtask

    task automatic t_bus_enable();
        @(negedge clk);
        sel = 2'b11; cs_n = 1'b1; rd_n = 1'b0;
        #1 chk("R2 oe with cs high", {7'd0, bus_oe}, 8'h00);
        cs_n = 1'b0; rd_n = 1'b1;
        #1 chk("R2 oe with rd high", {7'd0, bus_oe}, 8'h00);
        rd_n = 1'b0;
        #1 chk("R2 oe with read", {7'd0, bus_oe}, 8'h01);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_outputs();
        logic [7:0] v;
        bus_wr(2'b11, 8'h80);
        chk("R4 pa_oe all output", pa_oe, 8'hFF);
        chk("R4 pb_oe all output", pb_oe, 8'hFF);
        chk("R4 pc_oe all output", pc_oe, 8'hFF);
        bus_wr(2'b00, 8'h5A);
        chk("R10 pa_out", pa_out, 8'h5A);
        bus_wr(2'b01, 8'hC3);
        chk("R10 pb_out", pb_out, 8'hC3);
        bus_wr(2'b10, 8'h96);
        chk("R10 pc_out", pc_out, 8'h96);
        bus_rd(2'b00, v); chk("R1 read A latch", v, 8'h5A);
        bus_rd(2'b01, v); chk("R1 read B latch", v, 8'hC3);
        bus_rd(2'b10, v); chk("R1 read C latch", v, 8'h96);
    endtask

    task automatic t_clear();
        bus_wr(2'b11, 8'h92);
        chk("R6 A input keeps latch", pa_out, 8'h5A);
        chk("R6 B input keeps latch", pb_out, 8'hC3);
        chk("R6 C output cleared", pc_out, 8'h00);
        chk("R4 mixed pc_oe", pc_oe, 8'hFF);
        chk("R4 mixed pa_oe", pa_oe, 8'h00);
        bus_wr(2'b11, 8'h80);
        chk("R6 A cleared on output", pa_out, 8'h00);
        chk("R6 B cleared on output", pb_out, 8'h00);
    endtask

    task automatic t_ctl_modes();
        logic [7:0] v;
        bus_wr(2'b11, 8'hE5);
        bus_rd(2'b11, v);
        chk("R5 control readback", v, 8'hE5);
        chk("R5 mode bits no effect pa_oe", pa_oe, 8'hFF);
        chk("R5 mode bits no effect pc_oe", pc_oe, 8'hF0);
        chk("R5 mode bits no effect pb_oe", pb_oe, 8'hFF);
    endtask

    task automatic t_bsr();
        logic [7:0] v;
        bus_wr(2'b11, 8'h80);
        bus_wr(2'b10, 8'h00);
        bus_wr(2'b11, 8'h0B);
        chk("R7 set bit 5", pc_out, 8'h20);
        bus_wr(2'b11, 8'h01);
        chk("R7 set bit 0", pc_out, 8'h21);
        bus_wr(2'b11, 8'h0F);
        chk("R7 set bit 7", pc_out, 8'hA1);
        bus_wr(2'b11, 8'h0A);
        chk("R7 clear bit 5", pc_out, 8'h81);
        bus_rd(2'b11, v);
        chk("R7 control unchanged", v, 8'h80);
    endtask

    task automatic t_pa_latch();
        logic [7:0] v;
        bus_wr(2'b11, 8'h9B);
        @(negedge clk);
        pa_in = 8'h3C;
        @(negedge clk);
        sel = 2'b00; cs_n = 1'b0; rd_n = 1'b0;
        #1 chk("R8 read captured value", bus_rdata, 8'h3C);
        @(negedge clk);
        pa_in = 8'hC3;
        @(negedge clk);
        chk("R8 pin change during read ignored", bus_rdata, 8'h3C);
        cs_n = 1'b1; rd_n = 1'b1;
        @(negedge clk);
        bus_rd(2'b00, v);
        chk("R8 new value after read", v, 8'hC3);
    endtask

    task automatic t_direct_in();
        logic [7:0] v;
        bus_wr(2'b11, 8'h83);
        bus_wr(2'b10, 8'hA5);
        pc_in = 8'h3C;
        bus_rd(2'b10, v);
        chk("R9 C nibble mix", v, 8'hAC);
        @(negedge clk);
        sel = 2'b01; cs_n = 1'b0; rd_n = 1'b0; pb_in = 8'h77;
        #1 chk("R9 B live pins", bus_rdata, 8'h77);
        pb_in = 8'h18;
        #1 chk("R9 B follows pins", bus_rdata, 8'h18);
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic t_input_write();
        logic [7:0] v;
        bus_wr(2'b11, 8'h9B);
        pb_in = 8'h21;
        bus_wr(2'b01, 8'h55);
        chk("R11 oe stays low", pb_oe, 8'h00);
        bus_rd(2'b01, v);
        chk("R11 read returns pins", v, 8'h21);
        bus_wr(2'b11, 8'h99);
        chk("R11 cleared on output", pb_out, 8'h00);
        bus_rd(2'b01, v);
        chk("R11 read after switch", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_bus_enable();
        t_outputs();
        t_clear();
        t_ctl_modes();
        t_bsr();
        t_pa_latch();
        t_direct_in();
        t_input_write();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule